// File: doc/BRIEF.md
# Multi-Window Address Router

This block takes one request channel (address, write data, direction and a flag marking requests issued by the boot sequencer) and compares each address against four programmable address windows. A peripheral window and two host-bus base windows serve every requester. A memory window serves only write commands from the boot sequencer, whose data it steers to the main-memory port. A request goes to exactly one target port, or it receives a one-cycle error response when no window claims it.

Each window is held in a pair of bound registers written through a small configuration port. The low bound is inclusive and the high bound is exclusive. A window is live only while its low bound is below its high bound, so software turns a window off by making the bounds equal or inverted. Software is expected to pass through that off state when it moves a window, so that two live windows never share an address. If they do, the router still picks the lowest-indexed window and raises a sticky overlap flag. A read sent to the peripheral window stalls the requester until the peripheral returns the read data.

Top module: `arw_router`

## Requirements
- R1: After reset every window is off (low bound 1, high bound 0), `req_ready` is 1, no target valid or response is raised and `overlap_err` is 0, so any request then receives an error response.
- R2: A request accepted when `req_valid` and `req_ready` are both 1 raises exactly the chosen target's valid for one cycle in the next cycle, with `tgt_addr`, `tgt_wdata` and `tgt_write` equal to the accepted values. An address hits a window when it is at least the low bound and below the high bound.
- R3: A window whose low and high bounds are equal claims no address.
- R4: A window whose low bound is above its high bound claims no address.
- R5: The memory window (index 1) claims only requests with `req_boot` = 1 and `req_write` = 1; other requests inside it are decoded as if it were off.
- R6: A request that no live, eligible window claims produces `rsp_valid` = 1 and `rsp_err` = 1 for one cycle in the next cycle, with `rsp_rdata` all ones when the request was a read.
- R7: When two or more live, eligible windows claim an address, the lowest index wins (peripheral 0, memory 1, host A 2, host B 3) and `overlap_err` becomes 1 and stays 1 until reset.
- R8: A read routed to the peripheral window holds `req_ready` at 0 from its issue cycle until the cycle after `per_rd_done`; in that cycle `rsp_valid` = 1, `rsp_err` = 0 and `rsp_rdata` carries the `per_rd_data` given with `per_rd_done`.
- R9: In any cycle at most one of `per_valid`, `mem_valid`, `host_valid[0]`, `host_valid[1]` and an error response is active.
- R10: A bound written with `cfg_we` = 1 (`cfg_sel[2:1]` = window index, `cfg_sel[0]` = 0 for the low bound, 1 for the high bound) decides a request presented in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Bound register write strobe |
| cfg_sel | input | 3 | Window index in [2:1], high-bound select in [0] |
| cfg_wdata | input | ADDR_W | Bound value to write |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Router can take a request this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_boot | input | 1 | Request comes from the boot sequencer |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| per_valid | output | 1 | Request to the peripheral target |
| mem_valid | output | 1 | Write to the main-memory port |
| host_valid | output | 2 | Request to host window A [0] or B [1] |
| tgt_write | output | 1 | Direction of the issued request |
| tgt_addr | output | ADDR_W | Address of the issued request |
| tgt_wdata | output | DATA_W | Data of the issued request |
| per_rd_done | input | 1 | Peripheral read data is ready |
| per_rd_data | input | DATA_W | Peripheral read data |
| rsp_valid | output | 1 | Response to the requester |
| rsp_err | output | 1 | Response is a no-target error |
| rsp_rdata | output | DATA_W | Read data of the response |
| overlap_err | output | 1 | Sticky flag: a request hit two live windows |

## Verification
The bench sweeps every address of a 6-bit configuration under several window layouts and request kinds and predicts each route from its own copy of the bounds. It aims at the window edges, where an off-by-one compare would claim the high bound or miss the low bound, and at equal and inverted bounds, which a design testing only one relation would leave live. Boot reads and processor writes inside the memory window catch a design that forwards them to memory, overlapping layouts catch a wrong priority or a flag that clears itself, and peripheral reads catch a router that accepts a new request before the read returns. A bound written one cycle before a request catches a stale comparison.

// File: rtl/arw_pkg.sv
// Shared definitions for the address window router.
// Assumes exactly four windows with the fixed roles listed below.
package arw_pkg;
    localparam int WIN_N   = 4;
    localparam int WIN_PER = 0;
    localparam int WIN_MEM = 1;
    localparam int WIN_HA  = 2;
    localparam int WIN_HB  = 3;
    localparam int SEL_W   = $clog2(WIN_N) + 1;

    typedef enum logic [2:0] {
        TGT_PER   = 3'd0,
        TGT_MEM   = 3'd1,
        TGT_HOSTA = 3'd2,
        TGT_HOSTB = 3'd3,
        TGT_NONE  = 3'd4
    } tgt_e;
endpackage

// File: rtl/arw_window.sv
// One address window: a low/high bound register pair and its hit compare.
// Low is inclusive, high exclusive; the window is live only when low < high.
// Assumes cfg_sel[SEL_W-1:1] selects the window and cfg_sel[0] the bound.
module arw_window #(
    parameter int ADDR_W = 16,
    parameter int SEL_W  = 3,
    parameter int IDX    = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              win_live,
    output logic              win_hit
);
    localparam logic [SEL_W-2:0] MY_IDX = (SEL_W-1)'(IDX);

    logic [ADDR_W-1:0] lo_q;
    logic [ADDR_W-1:0] hi_q;
    logic              sel_me;

    assign sel_me = cfg_we && (cfg_sel[SEL_W-1:1] == MY_IDX);

    // Bound registers: reset to an inverted pair, update in one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= ADDR_W'(1);
            hi_q <= '0;
        end else if (sel_me) begin
            if (cfg_sel[0]) hi_q <= cfg_wdata;
            else            lo_q <= cfg_wdata;
        end
    end

    // Hit compare: live window and address inside [lo, hi).
    always_comb begin
        win_live = (lo_q < hi_q);
        win_hit  = win_live && (probe_addr >= lo_q) && (probe_addr < hi_q);
    end
endmodule

// File: rtl/arw_decode.sv
// Picks the target from the per-window hit vector.
// Masks the memory window to boot writes, grants the lowest index and
// flags when more than one eligible window hits. Purely combinational.
module arw_decode
    import arw_pkg::*;
#(
    parameter int NW = WIN_N
) (
    input  logic [NW-1:0] hit_vec,
    input  logic          req_write,
    input  logic          req_boot,
    output tgt_e          dec_tgt,
    output logic          dec_multi
);
    logic [NW-1:0] elig;
    int unsigned   n_hit;

    // Eligibility: memory window only for boot-sequencer writes.
    always_comb begin
        elig = hit_vec;
        elig[WIN_MEM] = hit_vec[WIN_MEM] && req_boot && req_write;
    end

    // Priority select, lowest index wins, and hit count.
    always_comb begin
        dec_tgt = TGT_NONE;
        n_hit   = 0;
        for (int i = NW - 1; i >= 0; i--) begin
            if (elig[i]) begin
                dec_tgt = tgt_e'(3'(i));
                n_hit   = n_hit + 1;
            end
        end
        dec_multi = (n_hit > 1);
    end
endmodule

// File: rtl/arw_issue.sv
// Registered issue stage: holds the accepted request one cycle, drives the
// target valids or the error response, and stalls on peripheral reads until
// the read data returns. Assumes targets other than a peripheral read
// take a request in the cycle it is issued.
module arw_issue
    import arw_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  tgt_e              dec_tgt,
    input  logic              dec_multi,
    output logic              req_ready,
    output logic              per_valid,
    output logic              mem_valid,
    output logic [1:0]        host_valid,
    output logic              tgt_write,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [DATA_W-1:0] tgt_wdata,
    input  logic              per_rd_done,
    input  logic [DATA_W-1:0] per_rd_data,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              overlap_err
);
    logic              stg_valid;
    tgt_e              stg_tgt;
    logic              stg_write;
    logic [ADDR_W-1:0] stg_addr;
    logic [DATA_W-1:0] stg_wdata;
    logic              wait_rd;
    logic              rd_rsp_q;
    logic [DATA_W-1:0] rd_data_q;
    logic              ovl_q;
    logic              accept;
    logic              stg_per_rd;

    // Handshake: no new request while a peripheral read is outstanding.
    always_comb begin
        stg_per_rd = stg_valid && (stg_tgt == TGT_PER) && !stg_write;
        req_ready  = !stg_per_rd && !wait_rd;
        accept     = req_valid && req_ready;
    end

    // Issue stage register: captures the request and its decoded target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_valid <= 1'b0;
            stg_tgt   <= TGT_NONE;
            stg_write <= 1'b0;
            stg_addr  <= '0;
            stg_wdata <= '0;
        end else begin
            stg_valid <= accept;
            if (accept) begin
                stg_tgt   <= dec_tgt;
                stg_write <= req_write;
                stg_addr  <= req_addr;
                stg_wdata <= req_wdata;
            end
        end
    end

    // Read wait state: set after a peripheral read issues, cleared on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_rd <= 1'b0;
        end else if (stg_per_rd) begin
            wait_rd <= 1'b1;
        end else if (wait_rd && per_rd_done) begin
            wait_rd <= 1'b0;
        end
    end

    // Read response register: one-cycle pulse with the returned data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_rsp_q  <= 1'b0;
            rd_data_q <= '0;
        end else begin
            rd_rsp_q <= wait_rd && per_rd_done;
            if (wait_rd && per_rd_done) rd_data_q <= per_rd_data;
        end
    end

    // Sticky overlap flag: set on any accepted multi-window hit.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ovl_q <= 1'b0;
        else if (accept && dec_multi) ovl_q <= 1'b1;
    end

    // Output decode of the issue stage.
    always_comb begin
        per_valid     = stg_valid && (stg_tgt == TGT_PER);
        mem_valid     = stg_valid && (stg_tgt == TGT_MEM);
        host_valid[0] = stg_valid && (stg_tgt == TGT_HOSTA);
        host_valid[1] = stg_valid && (stg_tgt == TGT_HOSTB);
        tgt_write     = stg_write;
        tgt_addr      = stg_addr;
        tgt_wdata     = stg_wdata;
        rsp_err       = stg_valid && (stg_tgt == TGT_NONE);
        rsp_valid     = rsp_err || rd_rsp_q;
        if (rsp_err)       rsp_rdata = '1;
        else if (rd_rsp_q) rsp_rdata = rd_data_q;
        else               rsp_rdata = '0;
        overlap_err   = ovl_q;
    end
endmodule

// File: rtl/arw_router.sv
// Top of the address window router: four bound-pair windows, a priority
// decoder and a registered issue stage with one cycle of decode latency.
// Assumes software moves a window through its off state; overlaps are
// still resolved by index and reported through overlap_err.
module arw_router
    import arw_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_boot,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              per_valid,
    output logic              mem_valid,
    output logic [1:0]        host_valid,
    output logic              tgt_write,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [DATA_W-1:0] tgt_wdata,
    input  logic              per_rd_done,
    input  logic [DATA_W-1:0] per_rd_data,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              overlap_err
);
    logic [WIN_N-1:0] hit_vec;
    logic [WIN_N-1:0] live_vec;
    tgt_e             dec_tgt;
    logic             dec_multi;

    // One window instance per bound pair.
    for (genvar w = 0; w < WIN_N; w++) begin : g_win
        arw_window #(
            .ADDR_W (ADDR_W),
            .SEL_W  (SEL_W),
            .IDX    (w)
        ) win_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg_we     (cfg_we),
            .cfg_sel    (cfg_sel),
            .cfg_wdata  (cfg_wdata),
            .probe_addr (req_addr),
            .win_live   (live_vec[w]),
            .win_hit    (hit_vec[w])
        );
    end

    arw_decode #(.NW(WIN_N)) dec_i (
        .hit_vec   (hit_vec),
        .req_write (req_write),
        .req_boot  (req_boot),
        .dec_tgt   (dec_tgt),
        .dec_multi (dec_multi)
    );

    arw_issue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) iss_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .dec_tgt     (dec_tgt),
        .dec_multi   (dec_multi),
        .req_ready   (req_ready),
        .per_valid   (per_valid),
        .mem_valid   (mem_valid),
        .host_valid  (host_valid),
        .tgt_write   (tgt_write),
        .tgt_addr    (tgt_addr),
        .tgt_wdata   (tgt_wdata),
        .per_rd_done (per_rd_done),
        .per_rd_data (per_rd_data),
        .rsp_valid   (rsp_valid),
        .rsp_err     (rsp_err),
        .rsp_rdata   (rsp_rdata),
        .overlap_err (overlap_err)
    );
endmodule

// File: rtl/arw_checker.sv
// Property checker for arw_router, attached with bind below.
module arw_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_boot,
    input logic              per_valid,
    input logic              mem_valid,
    input logic [1:0]        host_valid,
    input logic              tgt_write,
    input logic              per_rd_done,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              overlap_err
);
    AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({per_valid, mem_valid, host_valid, rsp_valid && rsp_err})); // R9

    AST_ROUTE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (per_valid || mem_valid || (host_valid != 2'b00)) |-> $past(req_valid && req_ready)); // R2

    AST_ERR_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> $past(req_valid && req_ready)); // R6

    AST_ERR_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err && !tgt_write) |-> (rsp_rdata == {DATA_W{1'b1}})); // R6

    AST_MEM_BOOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (tgt_write && $past(req_boot))); // R5

    AST_PER_READ_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (per_valid && !tgt_write) |-> !req_ready); // R8

    AST_READ_RSP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err) |-> $past(per_rd_done)); // R8

    AST_OVERLAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overlap_err |=> overlap_err); // R7
endmodule

bind arw_router arw_checker #(.DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_boot    (req_boot),
    .per_valid   (per_valid),
    .mem_valid   (mem_valid),
    .host_valid  (host_valid),
    .tgt_write   (tgt_write),
    .per_rd_done (per_rd_done),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .rsp_rdata   (rsp_rdata),
    .overlap_err (overlap_err)
);

// File: tb/arw_router_tb.sv
`timescale 1ns/1ps
module arw_router_tb_top;
    localparam int AW = 6;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic          req_boot = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          per_valid;
    logic          mem_valid;
    logic [1:0]    host_valid;
    logic          tgt_write;
    logic [AW-1:0] tgt_addr;
    logic [DW-1:0] tgt_wdata;
    logic          per_rd_done = 1'b0;
    logic [DW-1:0] per_rd_data = '0;
    logic          rsp_valid;
    logic          rsp_err;
    logic [DW-1:0] rsp_rdata;
    logic          overlap_err;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 1'b0;

    logic [AW-1:0] m_lo [4];
    logic [AW-1:0] m_hi [4];
    bit            m_ovl = 1'b0;

    always #2 clk = ~clk;

    arw_router #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_boot(req_boot), .req_addr(req_addr),
        .req_wdata(req_wdata), .per_valid(per_valid), .mem_valid(mem_valid),
        .host_valid(host_valid), .tgt_write(tgt_write), .tgt_addr(tgt_addr),
        .tgt_wdata(tgt_wdata), .per_rd_done(per_rd_done),
        .per_rd_data(per_rd_data), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .overlap_err(overlap_err)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Write one bound; called at a negedge, returns at a negedge.
    task automatic set_bound(input int win, input bit hi, input int val);
        cfg_we    = 1'b1;
        cfg_sel   = {2'(win), hi};
        cfg_wdata = AW'(val);
        @(negedge clk);
        cfg_we = 1'b0;
        if (hi) m_hi[win] = AW'(val);
        else    m_lo[win] = AW'(val);
    endtask

    task automatic set_win(input int win, input int lo, input int hi);
        set_bound(win, 1'b0, lo);
        set_bound(win, 1'b1, hi);
    endtask

    // Reference route: 0..3 window index, 4 no target.
    function automatic int model_tgt(input int a, input bit wr, input bit boot, output bit multi);
        int t = 4;
        int n = 0;
        for (int w = 3; w >= 0; w--) begin
            bit hit = (m_lo[w] < m_hi[w]) && (a >= int'(m_lo[w])) && (a < int'(m_hi[w]));
            if (w == 1) hit = hit && boot && wr;
            if (hit) begin
                t = w;
                n++;
            end
        end
        multi = (n > 1);
        return t;
    endfunction

    // One request; called at a negedge, returns at a negedge.
    task automatic do_req(input int a, input bit wr, input bit boot, input string tag);
        bit multi;
        int t;
        logic [4:0] exp_vec;
        logic [4:0] act_vec;
        logic [DW-1:0] wd;
        logic [DW-1:0] rd;
        t  = model_tgt(a, wr, boot, multi);
        wd = DW'(16'h5A00 ^ (a * 37));
        rd = DW'(16'hC300 + a);
        req_valid = 1'b1;
        req_addr  = AW'(a);
        req_write = wr;
        req_boot  = boot;
        req_wdata = wd;
        chk(req_ready == 1'b1, tag, req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        if (multi) m_ovl = 1'b1;
        exp_vec = 5'b00000;
        exp_vec[t] = 1'b1;
        act_vec = {rsp_valid && rsp_err, host_valid[1], host_valid[0], mem_valid, per_valid};
        // R9: exactly the expected route, nothing else
        chk(act_vec == exp_vec, tag, act_vec, exp_vec);
        chk(overlap_err == m_ovl, "R7", overlap_err, m_ovl);
        if (t < 4) begin
            chk(tgt_addr == AW'(a) && tgt_write == wr, tag, {tgt_write, tgt_addr}, {wr, AW'(a)});
            if (wr) chk(tgt_wdata == wd, tag, tgt_wdata, wd);
        end else if (!wr) begin
            chk(rsp_rdata == '1, "R6", rsp_rdata, 16'hFFFF);
        end
        if (t == 0 && !wr) begin
            chk(req_ready == 1'b0, "R8", req_ready, 0);
            @(negedge clk);
            chk(req_ready == 1'b0 && rsp_valid == 1'b0, "R8", {req_ready, rsp_valid}, 0);
            per_rd_done = 1'b1;
            per_rd_data = rd;
            @(negedge clk);
            per_rd_done = 1'b0;
            chk(rsp_valid && !rsp_err && rsp_rdata == rd, "R8", {rsp_valid, rsp_err, rsp_rdata}, {2'b10, rd});
            chk(req_ready == 1'b1, "R8", req_ready, 1);
        end
    endtask

    task automatic sweep(input string tag);
        for (int a = 0; a < 64; a++) do_req(a, 1'b1, 1'b0, tag);
        for (int a = 0; a < 64; a++) do_req(a, 1'b1, 1'b1, tag);
        for (int a = 0; a < 64; a++) do_req(a, 1'b0, a[0], tag);
    endtask

    initial begin
        for (int w = 0; w < 4; w++) begin
            m_lo[w] = AW'(1);
            m_hi[w] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle state after reset
        chk(req_ready && !per_valid && !mem_valid && host_valid == 0 && !rsp_valid && !overlap_err,
            "R1", {req_ready, per_valid, mem_valid, host_valid, rsp_valid, overlap_err}, 7'b1000000);
        for (int a = 0; a < 64; a += 7) do_req(a, a[1], a[0], "R1");

        // Disjoint layout: route by window, memory only for boot writes
        set_win(0, 8, 16);
        set_win(1, 16, 32);
        set_win(2, 40, 48);
        set_win(3, 48, 60);
        sweep("R2");
        for (int a = 12; a < 36; a++) do_req(a, a[0], ~a[0], "R5");
        for (int a = 0; a < 64; a += 3) do_req(a, 1'b0, 1'b0, "R6");

        // Equal bounds switch the peripheral window off
        set_win(0, 20, 20);
        sweep("R3");

        // Inverted bounds switch host window A off
        set_win(2, 50, 45);
        sweep("R4");

        // Bound written the cycle before the request
        set_bound(0, 1'b0, 0);
        do_req(0, 1'b1, 1'b0, "R10");
        set_bound(0, 1'b1, 4);
        do_req(3, 1'b1, 1'b0, "R10");
        do_req(4, 1'b0, 1'b0, "R10");

        // Overlap: host B over peripheral and memory
        set_win(3, 2, 24);
        sweep("R7");
        set_win(3, 60, 62);
        for (int a = 0; a < 64; a += 5) do_req(a, 1'b1, 1'b0, "R7");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule